// File: doc/BRIEF.md
# Iterative 32-bit add-rotate-xor keyed permutation

This core scrambles a 16-word state of 32-bit words under a 16-word message that acts as the key. The state is viewed as a 4×4 array of words: word i sits in row i/4 and column i%4. Each round first mixes the four columns and then the four diagonals. Each half-round uses four identical mixers that work side by side. Which message word, and which fixed constant word, a mixer uses is set by one of ten fixed index permutations, picked by the round number modulo ten.

A request is a one-cycle start pulse with the 512-bit state and 512-bit message beside it. One half-round is done per clock, so the fourteen rounds finish 28 clocks after the request is taken. A single-cycle done pulse then marks the result on the output. The result stays there until the next accepted request. The core does nothing before or after the permutation: initial state set-up, counters, padding and feed-forward belong to the logic around it.

Top module: `arx_perm_core`

## Requirements
- R1: The reset `rst_n` is asynchronous and active low. It drives `done` low and `state_out` to all zeros. A run cut short by reset never produces a done pulse.
- R2: Word i (0..15) of `state_in`, `msg_in` and `state_out` occupies bits [32i+31:32i]. A start sampled high at a rising clock edge while the core is idle loads both inputs at that edge.
- R3: `done` rises exactly 28 rising edges after the edge that accepted the request (two per round over 14 rounds). It stays high for exactly one cycle.
- R4: A mixer on words (a,b,c,d) with key words x0, x1 computes, in this order: a=a+b+x0; d=(d^a) rotated right by 16; c=c+d; b=(b^c) rotated right by 12; a=a+b+x1; d=(d^a) rotated right by 8; c=c+d; b=(b^c) rotated right by 7. All sums wrap modulo 2^32.
- R5: A round first mixes the column groups (0,4,8,12), (1,5,9,13), (2,6,10,14), (3,7,11,15) as mixers 0..3. It then mixes the diagonal groups (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14) as mixers 4..7, using the column results.
- R6: In round r, let P be the permutation numbered r mod 10, and let p=P[2i] and q=P[2i+1] for mixer i. Then x0 = m[p] ^ u[q] and x1 = m[q] ^ u[p]. Rounds 10..13 therefore reuse permutations 0..3. The u words are the sixteen fixed 32-bit constants of the algorithm.
- R7: A start while a run is in progress is ignored. The running result and its done timing are unchanged.
- R8: After the done pulse, `state_out` holds the result and `done` stays low until another request is accepted.
- R9: A start during the done cycle is accepted. It begins a new 28-cycle run with the new inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| state_in | input | 512 | Input state, 16 words |
| msg_in | input | 512 | Message key, 16 words |
| done | output | 1 | One-cycle pulse, result valid |
| state_out | output | 512 | Permuted state, held until next request |

## Verification
Two things can fall in the same cycle: completion of one run and the request that opens the next. The done cycle is the first idle cycle, so a start raised exactly then must be taken rather than lost. The bench provokes this by driving a new request in the very cycle it sees `done`. It judges the overlap by three checks: the first result was visible in that cycle, the second result matches the model, and it arrives 28 edges later. A start during a run is also driven part-way through. It is judged by an unchanged result and done timing.

// File: rtl/arx_perm_pkg.sv
package arx_perm_pkg;

  localparam int WORD_W  = 32;
  localparam int NWORDS  = 16;
  localparam int STATE_W = WORD_W * NWORDS;
  localparam int ROT_A   = 16;
  localparam int ROT_B   = 12;
  localparam int ROT_C   = 8;
  localparam int ROT_D   = 7;
  localparam int NPERM   = 10;

  typedef logic [WORD_W-1:0]             word_t;
  typedef logic [NWORDS-1:0][WORD_W-1:0] state_t;
  typedef logic [3:0][WORD_W-1:0]        quad_t;   // [0]=a [1]=b [2]=c [3]=d

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t u_word(input logic [3:0] idx);
    case (idx)
      4'd0:  return 32'h243F6A88;
      4'd1:  return 32'h85A308D3;
      4'd2:  return 32'h13198A2E;
      4'd3:  return 32'h03707344;
      4'd4:  return 32'hA4093822;
      4'd5:  return 32'h299F31D0;
      4'd6:  return 32'h082EFA98;
      4'd7:  return 32'hEC4E6C89;
      4'd8:  return 32'h452821E6;
      4'd9:  return 32'h38D01377;
      4'd10: return 32'hBE5466CF;
      4'd11: return 32'h34E90C6C;
      4'd12: return 32'hC0AC29B7;
      4'd13: return 32'hC97C50DD;
      4'd14: return 32'h3F84D5B5;
      default: return 32'hB5470917;
    endcase
  endfunction

  // One permutation per row, first entry in the top nibble.
  function automatic logic [63:0] perm_row(input logic [3:0] row);
    case (row)
      4'd0: return 64'h0123456789ABCDEF;
      4'd1: return 64'hEA489FD61C02B753;
      4'd2: return 64'hB8C052FDAE367194;
      4'd3: return 64'h7931DCBE265A40F8;
      4'd4: return 64'h905724AFE1BC683D;
      4'd5: return 64'h2C6A0B834D75FE19;
      4'd6: return 64'hC51FED4A0763928B;
      4'd7: return 64'hDB7EC13950F4862A;
      4'd8: return 64'h6FE9B308C2D714A5;
      default: return 64'hA2847615FB9E3CD0;
    endcase
  endfunction

  function automatic logic [3:0] perm_at(input logic [3:0] row, input logic [3:0] pos);
    logic [63:0] t;
    t = perm_row(row);
    return t[{~pos, 2'b00} +: 4];
  endfunction

  function automatic quad_t arx_mix(input quad_t q, input word_t x0, input word_t x1);
    word_t a, b, c, d;
    a = q[0]; b = q[1]; c = q[2]; d = q[3];
    a = a + b + x0;
    d = rotr(d ^ a, ROT_A);
    c = c + d;
    b = rotr(b ^ c, ROT_B);
    a = a + b + x1;
    d = rotr(d ^ a, ROT_C);
    c = c + d;
    b = rotr(b ^ c, ROT_D);
    return {d, c, b, a};
  endfunction

endpackage

// File: rtl/arx_key_sel.sv
module arx_key_sel
  import arx_perm_pkg::*;
#(
  parameter int MIX_J = 0
) (
  input  logic       diag,
  input  logic [3:0] perm_sel,
  input  state_t     msg,
  output word_t      key0,
  output word_t      key1
);

  logic [3:0] pos0, pos1, idx0, idx1;

  always_comb begin
    pos0 = {diag, 2'(MIX_J), 1'b0};
    pos1 = {diag, 2'(MIX_J), 1'b1};
    idx0 = perm_at(perm_sel, pos0);
    idx1 = perm_at(perm_sel, pos1);
    key0 = msg[idx0] ^ u_word(idx1);
    key1 = msg[idx1] ^ u_word(idx0);
  end

endmodule

// File: rtl/arx_mixer.sv
module arx_mixer
  import arx_perm_pkg::*;
(
  input  quad_t q_in,
  input  word_t key0,
  input  word_t key1,
  output quad_t q_out
);

  always_comb q_out = arx_mix(q_in, key0, key1);

endmodule

// File: rtl/arx_perm_ctrl.sv
module arx_perm_ctrl #(
  parameter int ROUNDS = 14,
  parameter int NPERM  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       accept,
  output logic       busy,
  output logic       diag,
  output logic [3:0] perm_sel,
  output logic       done
);

  localparam int STEPS = 2 * ROUNDS;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] step_q;
  logic [3:0]    perm_q;
  logic          busy_q, done_q, last_step;

  assign accept    = start && !busy_q;
  assign last_step = busy_q && (step_q == LAST);
  assign busy      = busy_q;
  assign diag      = step_q[0];
  assign perm_sel  = perm_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      perm_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= '0;
        perm_q <= '0;
      end else if (busy_q) begin
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + CW'(1);
          if (step_q[0])
            perm_q <= (perm_q == 4'(NPERM - 1)) ? 4'd0 : perm_q + 4'd1;
        end
      end
    end
  end

  p_step_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_step) |=> (busy_q && step_q == $past(step_q) + CW'(1)));
  p_done_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && $past(step_q) == LAST));
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_step && start) |=> (step_q != '0));
  p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && start) |=> (busy_q && step_q == '0));
  p_perm_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_step && step_q[0] && perm_q == 4'(NPERM - 1)) |=> (perm_q == 4'd0));
  p_perm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !step_q[0]) |=> (perm_q == $past(perm_q)));

endmodule

// File: rtl/arx_perm_core.sv
module arx_perm_core
  import arx_perm_pkg::*;
#(
  parameter int ROUNDS = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [STATE_W-1:0] state_in,
  input  logic [STATE_W-1:0] msg_in,
  output logic               done,
  output logic [STATE_W-1:0] state_out
);

  localparam int STEPS = 2 * ROUNDS;
  localparam int CW    = $clog2(STEPS + 1);

  logic       accept, busy, diag;
  logic [3:0] perm_sel;
  state_t     st_q, msg_q, st_col, st_dia, st_next;
  quad_t      mix_in  [4];
  quad_t      mix_out [4];
  word_t      key0 [4];
  word_t      key1 [4];
  logic [CW-1:0] lat_q;

  arx_perm_ctrl #(.ROUNDS(ROUNDS), .NPERM(NPERM)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .busy(busy),
    .diag(diag), .perm_sel(perm_sel), .done(done)
  );

  for (genvar j = 0; j < 4; j++) begin : g_mix
    assign mix_in[j][0] = st_q[j];
    assign mix_in[j][1] = diag ? st_q[4  + ((j + 1) % 4)] : st_q[4  + j];
    assign mix_in[j][2] = diag ? st_q[8  + ((j + 2) % 4)] : st_q[8  + j];
    assign mix_in[j][3] = diag ? st_q[12 + ((j + 3) % 4)] : st_q[12 + j];

    arx_key_sel #(.MIX_J(j)) u_key (
      .diag(diag), .perm_sel(perm_sel), .msg(msg_q),
      .key0(key0[j]), .key1(key1[j])
    );

    arx_mixer u_mixer (
      .q_in(mix_in[j]), .key0(key0[j]), .key1(key1[j]), .q_out(mix_out[j])
    );
  end

  for (genvar r = 0; r < 4; r++) begin : g_row
    for (genvar c = 0; c < 4; c++) begin : g_col
      assign st_col[4*r + c] = mix_out[c][r];
      assign st_dia[4*r + c] = mix_out[(c + 4 - r) % 4][r];
    end
  end

  assign st_next   = diag ? st_dia : st_col;
  assign state_out = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      msg_q <= '0;
      lat_q <= '0;
    end else if (accept) begin
      st_q  <= state_in;
      msg_q <= msg_in;
      lat_q <= '0;
    end else if (busy) begin
      st_q  <= st_next;
      lat_q <= lat_q + CW'(1);
    end
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == CW'(STEPS)));
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(st_q));
  p_key_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> (msg_q == $past(msg_q)));

endmodule

// File: tb/arx_perm_core_bench.sv
module arx_perm_core_bench;

  localparam int N_RND = 14;
  localparam int LAT   = 2 * N_RND;

  localparam logic [31:0] U_TB [16] = '{
    32'h243F6A88, 32'h85A308D3, 32'h13198A2E, 32'h03707344,
    32'hA4093822, 32'h299F31D0, 32'h082EFA98, 32'hEC4E6C89,
    32'h452821E6, 32'h38D01377, 32'hBE5466CF, 32'h34E90C6C,
    32'hC0AC29B7, 32'hC97C50DD, 32'h3F84D5B5, 32'hB5470917};

  localparam logic [63:0] SG_TB [10] = '{
    64'h0123456789ABCDEF, 64'hEA489FD61C02B753, 64'hB8C052FDAE367194,
    64'h7931DCBE265A40F8, 64'h905724AFE1BC683D, 64'h2C6A0B834D75FE19,
    64'hC51FED4A0763928B, 64'hDB7EC13950F4862A, 64'h6FE9B308C2D714A5,
    64'hA2847615FB9E3CD0};

  // stimulus table: {state seed, message seed}
  localparam logic [63:0] VEC [6] = '{
    64'h00000001_00000002, 64'hDEADBEEF_12345678, 64'hFFFFFFFF_FFFFFFFE,
    64'h80000000_00000001, 64'hA5A5A5A5_5A5A5A5A, 64'h0BADF00D_CAFEBABE};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [511:0] state_in = '0;
  logic [511:0] msg_in = '0;
  logic         done;
  logic [511:0] state_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  arx_perm_core u_arx_perm_core (
    .clk(clk), .rst_n(rst_n), .start(start), .state_in(state_in),
    .msg_in(msg_in), .done(done), .state_out(state_out)
  );

  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    logic [63:0] t;
    t = {x, x} >> n;
    return t[31:0];
  endfunction

  function automatic int sg(input int row, input int p);
    return int'((SG_TB[row] >> (4 * (15 - p))) & 64'hF);
  endfunction

  function automatic logic [127:0] g_ref(input logic [31:0] a0, b0, c0, d0, x0, x1);
    logic [31:0] a, b, c, d;
    a = a0; b = b0; c = c0; d = d0;
    a = a + b + x0;   d = ror(d ^ a, 16);
    c = c + d;        b = ror(b ^ c, 12);
    a = a + b + x1;   d = ror(d ^ a, 8);
    c = c + d;        b = ror(b ^ c, 7);
    return {a, b, c, d};
  endfunction

  // Diagonals handled by rotating rows, mixing columns, rotating back.
  function automatic logic [511:0] ref_perm(input logic [511:0] s_in, input logic [511:0] m_in);
    logic [31:0] v [16];
    logic [31:0] w [16];
    logic [31:0] m [16];
    logic [127:0] g;
    logic [511:0] res;
    for (int i = 0; i < 16; i++) begin
      v[i] = s_in[32*i +: 32];
      m[i] = m_in[32*i +: 32];
    end
    for (int r = 0; r < N_RND; r++) begin
      int row;
      row = r % 10;
      for (int i = 0; i < 4; i++) begin
        int p, q;
        p = sg(row, 2*i); q = sg(row, 2*i + 1);
        g = g_ref(v[i], v[4+i], v[8+i], v[12+i], m[p] ^ U_TB[q], m[q] ^ U_TB[p]);
        {v[i], v[4+i], v[8+i], v[12+i]} = g;
      end
      for (int rr = 0; rr < 4; rr++)
        for (int c = 0; c < 4; c++) w[4*rr + c] = v[4*rr + (c + rr) % 4];
      for (int i = 0; i < 4; i++) begin
        int p, q;
        p = sg(row, 8 + 2*i); q = sg(row, 9 + 2*i);
        g = g_ref(w[i], w[4+i], w[8+i], w[12+i], m[p] ^ U_TB[q], m[q] ^ U_TB[p]);
        {w[i], w[4+i], w[8+i], w[12+i]} = g;
      end
      for (int rr = 0; rr < 4; rr++)
        for (int c = 0; c < 4; c++) v[4*rr + (c + rr) % 4] = w[4*rr + c];
    end
    for (int i = 0; i < 16; i++) res[32*i +: 32] = v[i];
    return res;
  endfunction

  function automatic logic [511:0] fill(input logic [31:0] seed);
    logic [31:0] x;
    logic [511:0] r;
    x = seed | 32'h1;
    for (int i = 0; i < 16; i++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      r[32*i +: 32] = x;
    end
    return r;
  endfunction

  task automatic check_vec(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the accepting edge
  task automatic kick(input logic [511:0] s, input logic [511:0] m);
    start = 1'b1; state_in = s; msg_in = m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (done !== 1'b1 && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [511:0] s, m, e, e2, held;
    repeat (3) @(negedge clk);
    check_int("R1 done in reset", int'(done), 0);
    check_vec("R1 state_out in reset", state_out, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of vectors: R2, R4, R5, R6 by model comparison, R3 by latency
    for (int k = 0; k < 6; k++) begin
      s = fill(VEC[k][63:32]);
      m = fill(VEC[k][31:0]);
      kick(s, m);
      wait_done(lat);
      check_int("R3 latency", lat, LAT);
      check_vec("R2 R4 R5 R6 result", state_out, ref_perm(s, m));
      @(negedge clk);
      check_int("R3 done single cycle", int'(done), 0);
    end

    // all-zero input
    kick('0, '0);
    wait_done(lat);
    check_vec("R4 R6 all-zero result", state_out, ref_perm('0, '0));

    // start during a run must be ignored
    s = fill(32'h1357_9BDF); m = fill(32'h2468_ACE0);
    e = ref_perm(s, m);
    kick(s, m);
    repeat (4) @(negedge clk);
    start = 1'b1; state_in = fill(32'h7777_0001); msg_in = fill(32'h7777_0002);
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check_int("R7 latency with stray start", lat, LAT - 5);
    check_vec("R7 result with stray start", state_out, e);

    // hold after done
    held = state_out;
    lat = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done) lat++;
    end
    check_int("R8 no done while idle", lat, 0);
    check_vec("R8 result held", state_out, held);

    // back-to-back: new request in the done cycle
    s = fill(32'h0F0F_1111); m = fill(32'hF0F0_2222);
    e = ref_perm(s, m);
    kick(s, m);
    wait_done(lat);
    check_vec("R9 first result in done cycle", state_out, e);
    s = fill(32'h3333_4444); m = fill(32'h5555_6666);
    e2 = ref_perm(s, m);
    kick(s, m);
    wait_done(lat);
    check_int("R9 latency of chained run", lat, LAT);
    check_vec("R9 chained result", state_out, e2);

    // reset in mid-run
    @(negedge clk);
    kick(fill(32'h9999_AAAA), fill(32'hBBBB_CCCC));
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_vec("R1 state_out after mid-run reset", state_out, '0);
    check_int("R1 done after mid-run reset", int'(done), 0);
    rst_n = 1'b1;
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) lat++;
    end
    check_int("R1 abandoned run gives no done", lat, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule